// File: doc/BRIEF.md
# Integrating Slope Converter Sequencer

This block is the digital half of an integrating analog-to-digital converter. It drives the switch controls around an external integrator. These are a capacitor reset switch and three source selects: reference, unknown input and ground. It counts clock cycles while each source is integrated, and watches a single comparator bit that reports when the integrator output crosses its threshold. A conversion is started by a one-cycle start pulse. The requested mode is sampled together with that pulse.

In two-slope mode the reference is integrated for a fixed number of cycles. The input is then integrated until the comparator trips. In three-slope mode the reference, the input and ground are integrated one after another, and each interval ends on a comparator trip. The ground interval carries the comparator offset, because in that mode the threshold is a negative level and not zero. That interval is subtracted from the other two. When all intervals are known, a bit-serial restoring divider forms the mode's ratio as an unsigned fixed-point number with 8 fraction bits. A one-cycle done pulse then marks the raw counts and the ratio as valid. A 16-bit interval that never trips is cut off and flagged.

Top module: `slope_seq`

## Requirements
- R1: After reset the capacitor reset switch output is high, all three source enables are low, done and overflow are low, and the three counts and the ratio read 0.
- R2: A start pulse accepted while idle is followed by exactly one cycle in which the capacitor reset switch is released and all enables are low. The reference enable rises in the next cycle.
- R3: In two-slope mode (mode input 0 at start) the reference enable stays high for exactly REF_CYCLES cycles whatever the comparator reports, and count 1 reads REF_CYCLES.
- R4: In two-slope mode the input enable then stays high until the cycle in which the comparator is sampled high. Count 2 is the number of cycles it was high, including that cycle. The ground enable never rises, and count 3 reads 0.
- R5: In three-slope mode (mode input 1 at start) the reference, input and ground enables are raised in that order. Each one stays high until the comparator is sampled high, and counts 1, 2 and 3 hold the number of cycles each was high, including the trip cycle.
- R6: At most one source enable is high at any time. Between two different enables there is at least one cycle with all enables low. No enable is high while the capacitor reset switch is high.
- R7: In two-slope mode the ratio is floor(count1 * 256 / count2), saturated to 0xFFFF.
- R8: In three-slope mode the ratio is floor(N * 256 / D), saturated to 0xFFFF. N is count2 minus count3, clamped to 0 when negative. D is count1 minus count3, clamped to 0. D equal to 0 gives 0xFFFF.
- R9: Done is high for exactly one cycle per conversion. Counts and ratio are valid in that cycle and hold their values until the next start.
- R10: If an interval reaches 65535 counted cycles and the comparator is still low on the next cycle, the conversion ends. The overflow flag is set, that count reads 65535, the ratio reads 0xFFFF and done pulses. A count that reaches 65535 on the trip cycle is a normal result. Overflow clears at the next accepted start.
- R11: A start pulse arriving while a conversion is in progress is ignored. Mode, counts and results of the running conversion are unaffected, and no extra done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin a conversion |
| mode_i | input | 1 | Sampled with start: 0 two-slope, 1 three-slope |
| cmp_i | input | 1 | Comparator output, high once the integrator has crossed its threshold |
| cap_rst_o | output | 1 | Capacitor reset switch closed when high |
| ref_en_o | output | 1 | Integrate the reference |
| in_en_o | output | 1 | Integrate the unknown input |
| gnd_en_o | output | 1 | Integrate ground (three-slope only) |
| t1_o | output | 16 | Reference interval count |
| t2_o | output | 16 | Input interval count |
| t3_o | output | 16 | Ground interval count |
| ratio_o | output | 16 | Mode ratio, unsigned with 8 fraction bits |
| done_o | output | 1 | One-cycle pulse: counts and ratio valid |
| ovf_o | output | 1 | Last conversion was cut off by an interval timeout |

## Verification
The assertions assume the comparator bit is already synchronous to the clock. They also assume start lasts one cycle and that mode is valid in that cycle. The bench models the integrator as a counter clocked on the falling edge. It raises the comparator only after a programmed number of cycles of one enable, and drops it as soon as all enables go low. Start is held for a single cycle with mode set beside it. In two-slope mode the comparator is deliberately held high through the whole reference phase, which shows that the fixed interval ignores it.

// File: rtl/slope_pkg.sv
package slope_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_RUN,
    ST_GAP,
    ST_CALC,
    ST_DIV
  } seq_state_e;

  typedef enum logic {
    MODE_DUAL   = 1'b0,
    MODE_TRIPLE = 1'b1
  } slope_mode_e;
endpackage

// File: rtl/slope_cnt.sv
module slope_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         max_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                     cnt_d = '0;
    else if (en_i && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign max_o = (cnt_q == TOP);

  assert_hold_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (max_o && !clr_i) |=> max_o);

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && !max_o) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/slope_div.sv
module slope_div #(
  parameter int N_W = 24,
  parameter int D_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [N_W-1:0] num_i,
  input  logic [D_W-1:0] den_i,
  output logic [N_W-1:0] quo_o,
  output logic           valid_o
);
  localparam int CW = $clog2(N_W + 1);

  logic [N_W-1:0] dvd_q, dvd_d;
  logic [D_W-1:0] rem_q, rem_d, den_q, den_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           run_q, run_d, valid_q, valid_d;
  logic [D_W:0]   shl;
  logic [D_W+1:0] diff;

  assign shl  = {rem_q, dvd_q[N_W-1]};
  assign diff = {1'b0, shl} - {2'b00, den_q};

  always_comb begin
    dvd_d   = dvd_q;
    rem_d   = rem_q;
    den_d   = den_q;
    cnt_d   = cnt_q;
    run_d   = run_q;
    valid_d = 1'b0;
    if (start_i) begin
      dvd_d = num_i;
      rem_d = '0;
      den_d = den_i;
      cnt_d = CW'(N_W);
      run_d = 1'b1;
    end else if (run_q) begin
      if (!diff[D_W+1]) begin
        rem_d = diff[D_W-1:0];
        dvd_d = {dvd_q[N_W-2:0], 1'b1};
      end else begin
        rem_d = shl[D_W-1:0];
        dvd_d = {dvd_q[N_W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d   = 1'b0;
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q   <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      dvd_q   <= dvd_d;
      rem_q   <= rem_d;
      den_q   <= den_d;
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      valid_q <= valid_d;
    end
  end

  assign quo_o   = dvd_q;
  assign valid_o = valid_q;

  assert_rem_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && den_q != '0) |-> (rem_q < den_q));

  assert_valid_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
endmodule

// File: rtl/slope_seq.sv
module slope_seq
  import slope_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FRAC_W     = 8,
  parameter int REF_CYCLES = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic             cmp_i,
  output logic             cap_rst_o,
  output logic             ref_en_o,
  output logic             in_en_o,
  output logic             gnd_en_o,
  output logic [CNT_W-1:0] t1_o,
  output logic [CNT_W-1:0] t2_o,
  output logic [CNT_W-1:0] t3_o,
  output logic [CNT_W-1:0] ratio_o,
  output logic             done_o,
  output logic             ovf_o
);
  localparam int NPH = 3;
  localparam int N_W = CNT_W + FRAC_W;
  localparam logic [CNT_W-1:0] REF_LAST = CNT_W'(REF_CYCLES - 1);

  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  seq_state_e  state_q, state_d;
  slope_mode_e mode_q, mode_d;
  logic [1:0]  ph_q, ph_d;
  logic        ovf_q, ovf_d, done_q, done_d;
  logic [CNT_W-1:0] ratio_q, ratio_d;

  logic [CNT_W-1:0] cnt [NPH];
  logic [NPH-1:0]   at_max, cnt_en;
  logic             cnt_clr, accept;

  assign accept  = (state_q == ST_IDLE) && start_i;
  assign cnt_clr = accept;

  for (genvar k = 0; k < NPH; k++) begin : g_cnt
    assign cnt_en[k] = (state_q == ST_RUN) && (ph_q == 2'(k));
    slope_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_ni),
      .clr_i (cnt_clr),
      .en_i  (cnt_en[k]),
      .cnt_o (cnt[k]),
      .max_o (at_max[k])
    );
  end

  logic sel_max, ph_end, last_ph;
  always_comb begin
    case (ph_q)
      2'd0:    sel_max = at_max[0];
      2'd1:    sel_max = at_max[1];
      default: sel_max = at_max[2];
    endcase
  end
  assign ph_end  = (mode_q == MODE_DUAL && ph_q == 2'd0) ? (cnt[0] == REF_LAST) : cmp_i;
  assign last_ph = (mode_q == MODE_TRIPLE) ? (ph_q == 2'd2) : (ph_q == 2'd1);

  logic [CNT_W-1:0] num_c, den_c;
  logic [N_W-1:0]   quo;
  logic             div_start, div_valid;

  always_comb begin
    if (mode_q == MODE_DUAL) begin
      num_c = cnt[0];
      den_c = cnt[1];
    end else begin
      num_c = (cnt[1] > cnt[2]) ? cnt[1] - cnt[2] : '0;
      den_c = (cnt[0] > cnt[2]) ? cnt[0] - cnt[2] : '0;
    end
  end

  assign div_start = (state_q == ST_CALC);

  slope_div #(.N_W(N_W), .D_W(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_ni),
    .start_i (div_start),
    .num_i   ({num_c, {FRAC_W{1'b0}}}),
    .den_i   (den_c),
    .quo_o   (quo),
    .valid_o (div_valid)
  );

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    ph_d    = ph_q;
    ovf_d   = ovf_q;
    ratio_d = ratio_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_INIT;
        mode_d  = slope_mode_e'(mode_i);
        ovf_d   = 1'b0;
      end
      ST_INIT: begin
        state_d = ST_RUN;
        ph_d    = 2'd0;
      end
      ST_RUN: begin
        if (sel_max) begin
          state_d = ST_IDLE;
          ovf_d   = 1'b1;
          ratio_d = '1;
          done_d  = 1'b1;
        end else if (ph_end) begin
          state_d = last_ph ? ST_CALC : ST_GAP;
        end
      end
      ST_GAP: begin
        state_d = ST_RUN;
        ph_d    = ph_q + 1'b1;
      end
      ST_CALC: state_d = ST_DIV;
      ST_DIV: if (div_valid) begin
        state_d = ST_IDLE;
        ratio_d = (quo[N_W-1:CNT_W] != '0) ? '1 : quo[CNT_W-1:0];
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_DUAL;
      ph_q    <= 2'd0;
      ovf_q   <= 1'b0;
      ratio_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      ph_q    <= ph_d;
      ovf_q   <= ovf_d;
      ratio_q <= ratio_d;
      done_q  <= done_d;
    end
  end

  assign ref_en_o  = cnt_en[0];
  assign in_en_o   = cnt_en[1];
  assign gnd_en_o  = cnt_en[2];
  assign cap_rst_o = (state_q == ST_IDLE) || (state_q == ST_CALC) || (state_q == ST_DIV) ||
                     ((state_q == ST_GAP) && (mode_q == MODE_TRIPLE));
  assign t1_o      = cnt[0];
  assign t2_o      = cnt[1];
  assign t3_o      = cnt[2];
  assign ratio_o   = ratio_q;
  assign done_o    = done_q;
  assign ovf_o     = ovf_q;

  assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({ref_en_o, in_en_o, gnd_en_o}));

  assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(ref_en_o) || $rose(in_en_o) || $rose(gnd_en_o)) |->
      ($past({ref_en_o, in_en_o, gnd_en_o}) == 3'b000));

  assert_init_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=>
      (!cap_rst_o && !ref_en_o && !in_en_o && !gnd_en_o));

  assert_ref_len_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    ($fell(ref_en_o) && mode_q == MODE_DUAL && !ovf_o) |-> (t1_o == CNT_W'(REF_CYCLES)));

  assert_ignore_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> (mode_q == $past(mode_q)));

  assert_ovf_done_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ovf_o) |-> done_o);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/slope_seq_tb_top.sv
`timescale 1ns/1ps
module slope_seq_tb_top;
  localparam int REF = 256;
  localparam int NV  = 10;
  localparam int NEVER = 70000;

  logic clk, rst_n, start_i, mode_i, cmp_i;
  logic cap_rst_o, ref_en_o, in_en_o, gnd_en_o, done_o, ovf_o;
  logic [15:0] t1_o, t2_o, t3_o, ratio_o;

  slope_seq #(.CNT_W(16), .FRAC_W(8), .REF_CYCLES(REF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .cmp_i(cmp_i),
    .cap_rst_o(cap_rst_o), .ref_en_o(ref_en_o), .in_en_o(in_en_o), .gnd_en_o(gnd_en_o),
    .t1_o(t1_o), .t2_o(t2_o), .t3_o(t3_o), .ratio_o(ratio_o),
    .done_o(done_o), .ovf_o(ovf_o)
  );

  // {mode, k1, k2, k3}: comparator trip cycle per phase
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 16'd1,   16'd512,   16'd0},
    {1'b0, 16'd1,   16'd300,   16'd0},
    {1'b0, 16'd1,   16'd1,     16'd0},
    {1'b0, 16'd1,   16'd256,   16'd0},
    {1'b0, 16'd1,   16'd65535, 16'd0},
    {1'b1, 16'd300, 16'd200,   16'd50},
    {1'b1, 16'd100, 16'd100,   16'd20},
    {1'b1, 16'd50,  16'd60,    16'd50},
    {1'b1, 16'd80,  16'd30,    16'd40},
    {1'b1, 16'd400, 16'd90,    16'd10}
  };

  int checks = 0, errors = 0;
  int tgt [3];
  int bad_en = 0, bad_done = 0, ndone = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_ratio(input logic m, input int a, input int b, input int c);
    longint n, d, q;
    if (!m) begin n = REF; d = b; end
    else begin
      n = (b > c) ? b - c : 0;
      d = (a > c) ? a - c : 0;
    end
    if (d == 0) return 65535;
    q = (n * 256) / d;
    return (q > 65535) ? 65535 : q;
  endfunction

  // integrator/comparator model and port monitor
  initial begin
    logic [2:0] prev_en, en;
    logic prev_done;
    int k;
    prev_en = 3'b000; prev_done = 1'b0; k = 0; cmp_i = 1'b0;
    forever begin
      @(negedge clk);
      en = {gnd_en_o, in_en_o, ref_en_o};
      if (!$onehot0(en)) bad_en++;
      if (prev_en != 3'b000 && en != 3'b000 && en != prev_en) bad_en++;
      if (cap_rst_o && en != 3'b000) bad_en++;
      if (done_o) ndone++;
      if (done_o && prev_done) bad_done++;
      prev_en = en; prev_done = done_o;
      if (en == 3'b000) begin k = 0; cmp_i = 1'b0; end
      else begin
        k++;
        cmp_i = (k >= tgt[en[0] ? 0 : (en[1] ? 1 : 2)]);
      end
    end
  end

  task automatic pulse_start(input logic m);
    @(negedge clk); mode_i = m; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; mode_i = 1'b0;
  endtask

  task automatic wait_done(output logic seen);
    seen = 1'b0;
    for (int n = 0; n < 140000 && !seen; n++) begin
      @(negedge clk);
      if (done_o) seen = 1'b1;
    end
  endtask

  task automatic run_conv(input logic m, input int a, input int b, input int c, output logic seen);
    tgt[0] = a; tgt[1] = b; tgt[2] = c;
    pulse_start(m);
    wait_done(seen);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic seen;
    int n0;
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0;
    tgt[0] = NEVER; tgt[1] = NEVER; tgt[2] = NEVER;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 cap_rst", cap_rst_o, 1);
    chk("R1 enables", {ref_en_o, in_en_o, gnd_en_o}, 0);
    chk("R1 done/ovf", {done_o, ovf_o}, 0);
    chk("R1 counts", {t1_o, t2_o, t3_o}, 0);
    chk("R1 ratio", ratio_o, 0);

    // R2 init cycle, then reference enable
    tgt[0] = 1; tgt[1] = 700; tgt[2] = 0;
    @(negedge clk); mode_i = 1'b0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R2 init released", {cap_rst_o, ref_en_o, in_en_o, gnd_en_o}, 0);
    @(negedge clk);
    chk("R2 ref rises", {cap_rst_o, ref_en_o, in_en_o, gnd_en_o}, 4'b0100);
    wait_done(seen);
    chk("R9 done seen", seen, 1);
    chk("R4 t2", t2_o, 700);
    chk("R7 ratio", ratio_o, exp_ratio(1'b0, 1, 700, 0));

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      logic m;
      int a, b, c;
      v = VEC[i];
      m = v[48]; a = int'(v[47:32]); b = int'(v[31:16]); c = int'(v[15:0]);
      run_conv(m, a, b, c, seen);
      chk(m ? "R5 done" : "R4 done", seen, 1);
      chk(m ? "R5 t1" : "R3 t1", t1_o, m ? a : REF);
      chk(m ? "R5 t2" : "R4 t2", t2_o, b);
      chk(m ? "R5 t3" : "R4 t3", t3_o, m ? c : 0);
      chk(m ? "R8 ratio" : "R7 ratio", ratio_o, exp_ratio(m, a, b, c));
      chk("R10 no ovf", ovf_o, 0);
    end

    // R9 done lasts one cycle, results held
    @(negedge clk);
    chk("R9 done width", done_o, 0);
    chk("R9 ratio held", ratio_o, exp_ratio(1'b1, 400, 90, 10));

    // R11 start while busy ignored
    n0 = ndone;
    tgt[0] = 1; tgt[1] = 400; tgt[2] = 5;
    pulse_start(1'b0);
    repeat (100) @(negedge clk);
    pulse_start(1'b1);
    wait_done(seen);
    @(negedge clk);
    chk("R11 t2", t2_o, 400);
    chk("R11 t3", t3_o, 0);
    chk("R11 ratio", ratio_o, exp_ratio(1'b0, 1, 400, 0));
    chk("R11 single done", ndone - n0, 1);
    repeat (3) @(negedge clk);
    chk("R11 stays idle", {cap_rst_o, ref_en_o, in_en_o, gnd_en_o}, 4'b1000);

    // R10 overflow on the input interval
    run_conv(1'b0, 1, NEVER, 0, seen);
    chk("R10 done", seen, 1);
    chk("R10 ovf", ovf_o, 1);
    chk("R10 t2 sat", t2_o, 65535);
    chk("R10 ratio", ratio_o, 65535);
    chk("R10 t1", t1_o, REF);
    run_conv(1'b1, 120, 70, 20, seen);
    chk("R10 ovf cleared", ovf_o, 0);
    chk("R8 ratio after ovf", ratio_o, exp_ratio(1'b1, 120, 70, 20));

    repeat (2) @(negedge clk);
    chk("R6 enable rules", bad_en, 0);
    chk("R9 done pulses", bad_done, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule